// File: doc/BRIEF.md
# Three-Wire Wiper Stepping Master

This block sits on the host side of an up/down stepped resistor with 2^POS_W taps. The resistor is controlled by three lines: an active-low select, a direction level and an increment strobe. A step happens on each falling edge of the strobe while select is low. The block takes a single command in one of two forms. A relative command gives a direction and a step count. An absolute command gives a target tap, and the block works out the move from the tap position it tracks. Each command also carries a store flag. The block then plays out the whole select, step and deselect sequence on the three lines. Every minimum interval is held for a whole number of system clock cycles, rounded up from a time given in nanoseconds.

Each transaction ends in one of two ways. If the store flag is set, select rises while increment is high, which commits the tap to the resistor's nonvolatile memory, and then the long store-recovery time is waited out. If the store flag is clear, select rises while increment is low, so the tap changes but is not committed, and then the short deselect time is waited out. The block drives `busy` for the whole sequence and pulses `done` when the sequence ends.

The state machine runs through these states:
- IDLE: waits for a command.
- ARM_LOW: drops increment before selecting. This is used only for a zero-step move without store.
- SETUP: select and direction setup.
- PULSE_LOW and PULSE_HIGH: the two halves of each step.
- TAIL: the hold from the last strobe edge to deselect.
- DESELECT: the store or no-store recovery.
- RELEASE: the direction hold after increment is back high.

The transitions are:
- IDLE to ARM_LOW or SETUP when a command is accepted.
- ARM_LOW to SETUP.
- SETUP to PULSE_LOW, or to TAIL when there are no steps.
- PULSE_LOW to PULSE_HIGH, or to TAIL on the last step without store.
- PULSE_HIGH to PULSE_LOW, or to TAIL after the last step.
- TAIL to DESELECT, DESELECT to RELEASE, and RELEASE to IDLE.

Top module: `wiper_step_master`

## Requirements
- R1: After reset, `sel_n`=1, `inc`=1, `busy`=0, `done`=0, and `cur_pos` equals RESET_POS (0 by default).
- R2: Select falls, and direction takes its new value, in the same cycle a command is accepted. The first increment fall follows at least SETUP cycles later, where SETUP is the larger of the rounded-up select setup time and the rounded-up direction setup time.
- R3: While selected, increment stays low for at least LOW cycles. Between two steps it stays high for at least HIGH cycles, where HIGH is the larger of the rounded-up high time and (rounded-up cycle time minus LOW).
- R4: At least TAIL cycles pass from the last increment edge made while selected to the rise of select.
- R5: With `cmd_store`=1, select rises while increment is high, and select stays high for at least STORE cycles. With `cmd_store`=0, select rises while increment is low, and increment returns high no sooner than NOSTORE cycles later. Select does not fall again before the matching interval has passed.
- R6: Direction changes only while deselected, at least HOLD cycles after increment last rose, and it stays constant while select is low. `dir_up`=1 means up.
- R7: When `cmd_abs`=0, the number of steps is min(`cmd_steps`, distance to the end in the direction `cmd_up`). The tracked position moves one tap per step and saturates at 0 and 2^POS_W-1.
- R8: When `cmd_abs`=1, `cmd_target` is clamped to 2^POS_W-1. The block then makes |target-position| steps, upward when the target is at or above the position.
- R9: A move of zero steps still makes one select/deselect cycle that honours `cmd_store`. Without store, increment is first dropped while deselected and held for HOLD cycles.
- R10: A command is taken only when the block is idle, so `cmd_valid` while `busy` has no effect.
- R11: `done` is high for exactly one cycle: the first cycle with `busy`=0 after a transaction. `busy` lasts exactly the sum of the state intervals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, sampled while idle |
| cmd_abs | input | 1 | 1 = absolute target, 0 = relative steps |
| cmd_up | input | 1 | Relative direction, 1 = up |
| cmd_store | input | 1 | 1 = commit the tap at deselect |
| cmd_steps | input | STEP_W | Relative step count |
| cmd_target | input | POS_W+1 | Absolute target, clamped to the top tap |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| cur_pos | output | POS_W | Tracked tap position |
| sel_n | output | 1 | Active-low select line |
| inc | output | 1 | Increment strobe, steps on its falling edge |
| dir_up | output | 1 | Direction line, 1 = up |

## Verification
A wrong state or a bad timer load shows up first as an interval that is too short on the select or increment lines. A behavioural slave measures that interval in cycles at the very edge where it ends. A miscounted step counter or position register shows up as a wrong number of falling strobes, and as a tracked position that disagrees with the slave's tap once `busy` drops. A wrong ending shows up as the wrong value in the slave's nonvolatile copy at deselect. The length of `busy` and the cycle of `done` are compared exactly with the sum of the configured intervals, so even a single extra or missing cycle in any state is reported at the end of that transaction.

// File: rtl/wsm_pkg.sv
package wsm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM_LOW,
        ST_SETUP,
        ST_PULSE_LOW,
        ST_PULSE_HIGH,
        ST_TAIL,
        ST_DESELECT,
        ST_RELEASE
    } wsm_state_e;

    // Round a time in ns up to whole clock cycles, never below one cycle.
    function automatic int ns_to_cycles(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wsm_interval_timer.sv
module wsm_interval_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/wsm_move_planner.sv
module wsm_move_planner #(
    parameter int POS_W  = 5,
    parameter int STEP_W = 6
) (
    input  logic              cmd_abs,
    input  logic              cmd_up,
    input  logic [STEP_W-1:0] cmd_steps,
    input  logic [POS_W:0]    cmd_target,
    input  logic [POS_W-1:0]  cur_pos,
    output logic              plan_up,
    output logic [STEP_W-1:0] plan_count
);

    localparam int MAX_POS = (1 << POS_W) - 1;

    logic [POS_W-1:0]  tgt_clamped;
    logic [POS_W-1:0]  gap;
    logic [STEP_W-1:0] rel_room;

    always_comb begin
        tgt_clamped = (cmd_target > (POS_W+1)'(MAX_POS)) ? POS_W'(MAX_POS)
                                                          : cmd_target[POS_W-1:0];
        rel_room    = cmd_up ? STEP_W'(POS_W'(MAX_POS) - cur_pos) : STEP_W'(cur_pos);
        gap         = '0;
        if (cmd_abs) begin
            plan_up    = (tgt_clamped >= cur_pos);
            gap        = plan_up ? (tgt_clamped - cur_pos) : (cur_pos - tgt_clamped);
            plan_count = STEP_W'(gap);
        end else begin
            plan_up    = cmd_up;
            plan_count = (cmd_steps > rel_room) ? rel_room : cmd_steps;
        end
    end

endmodule

// File: rtl/wsm_pos_tracker.sv
module wsm_pos_tracker #(
    parameter int POS_W     = 5,
    parameter int RESET_POS = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             step_up,
    output logic [POS_W-1:0] pos
);

    localparam logic [POS_W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos <= POS_W'(RESET_POS);
        end else if (step_en) begin
            if (step_up && pos != TOP) begin
                pos <= pos + 1'b1;
            end else if (!step_up && pos != '0) begin
                pos <= pos - 1'b1;
            end
        end
    end

endmodule

// File: rtl/wiper_step_master.sv
module wiper_step_master
    import wsm_pkg::*;
#(
    parameter int CLK_NS         = 5,
    parameter int T_SEL_SETUP_NS = 100,
    parameter int T_DIR_SETUP_NS = 100,
    parameter int T_DIR_HOLD_NS  = 100,
    parameter int T_INC_LOW_NS   = 1000,
    parameter int T_INC_HIGH_NS  = 1000,
    parameter int T_INC_CYCLE_NS = 2000,
    parameter int T_TAIL_NS      = 1000,
    parameter int T_STORE_NS     = 10_000_000,
    parameter int T_NOSTORE_NS   = 250,
    parameter int POS_W          = 5,
    parameter int STEP_W         = 6,
    parameter int RESET_POS      = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_abs,
    input  logic              cmd_up,
    input  logic              cmd_store,
    input  logic [STEP_W-1:0] cmd_steps,
    input  logic [POS_W:0]    cmd_target,
    output logic              busy,
    output logic              done,
    output logic [POS_W-1:0]  cur_pos,
    output logic              sel_n,
    output logic              inc,
    output logic              dir_up
);

    // Interval lengths in cycles, all rounded up.
    localparam int SETUP_CYC   = max2(ns_to_cycles(T_SEL_SETUP_NS, CLK_NS),
                                      ns_to_cycles(T_DIR_SETUP_NS, CLK_NS));
    localparam int LOW_CYC     = ns_to_cycles(T_INC_LOW_NS, CLK_NS);
    localparam int HIGH_CYC    = max2(ns_to_cycles(T_INC_HIGH_NS, CLK_NS),
                                      ns_to_cycles(T_INC_CYCLE_NS, CLK_NS) - LOW_CYC);
    localparam int HOLD_CYC    = ns_to_cycles(T_DIR_HOLD_NS, CLK_NS);
    localparam int TAIL_CYC    = ns_to_cycles(T_TAIL_NS, CLK_NS);
    localparam int STORE_CYC   = ns_to_cycles(T_STORE_NS, CLK_NS);
    localparam int NOSTORE_CYC = ns_to_cycles(T_NOSTORE_NS, CLK_NS);
    localparam int LONGEST     = max2(max2(max2(SETUP_CYC, LOW_CYC), max2(HIGH_CYC, HOLD_CYC)),
                                      max2(max2(TAIL_CYC, STORE_CYC), NOSTORE_CYC));
    localparam int CNT_W       = $clog2(LONGEST + 1);

    wsm_state_e        state_q, state_d;
    logic [STEP_W-1:0] remain_q;
    logic              dir_q;
    logic              store_q;
    logic              arm_q;
    logic              store_nx;
    logic              arm_nx;
    logic              accept;
    logic              tmr_done;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_load_val;
    logic              plan_up;
    logic [STEP_W-1:0] plan_count;
    logic              step_en;

    assign accept   = (state_q == ST_IDLE) && cmd_valid;
    assign store_nx = accept ? cmd_store : store_q;
    assign arm_nx   = accept ? (plan_count == '0 && !cmd_store) : arm_q;
    assign step_en  = (state_q == ST_PULSE_LOW) && tmr_done;

    wsm_move_planner #(
        .POS_W  (POS_W),
        .STEP_W (STEP_W)
    ) i_planner (
        .cmd_abs    (cmd_abs),
        .cmd_up     (cmd_up),
        .cmd_steps  (cmd_steps),
        .cmd_target (cmd_target),
        .cur_pos    (cur_pos),
        .plan_up    (plan_up),
        .plan_count (plan_count)
    );

    wsm_pos_tracker #(
        .POS_W     (POS_W),
        .RESET_POS (RESET_POS)
    ) i_tracker (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (step_en),
        .step_up (dir_q),
        .pos     (cur_pos)
    );

    wsm_interval_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_load_val),
        .expired  (tmr_done)
    );

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (cmd_valid) state_d = (plan_count == '0 && !cmd_store) ? ST_ARM_LOW : ST_SETUP;
            ST_ARM_LOW:    if (tmr_done)  state_d = ST_SETUP;
            ST_SETUP:      if (tmr_done)  state_d = (remain_q == '0) ? ST_TAIL : ST_PULSE_LOW;
            ST_PULSE_LOW:  if (tmr_done)  state_d = (remain_q == STEP_W'(1) && !store_q) ? ST_TAIL : ST_PULSE_HIGH;
            ST_PULSE_HIGH: if (tmr_done)  state_d = (remain_q == '0) ? ST_TAIL : ST_PULSE_LOW;
            ST_TAIL:       if (tmr_done)  state_d = ST_DESELECT;
            ST_DESELECT:   if (tmr_done)  state_d = ST_RELEASE;
            ST_RELEASE:    if (tmr_done)  state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    // Interval for the state being entered.
    assign tmr_load = (state_d != state_q);

    always_comb begin
        unique case (state_d)
            ST_ARM_LOW,
            ST_RELEASE:    tmr_load_val = CNT_W'(HOLD_CYC - 1);
            ST_SETUP:      tmr_load_val = CNT_W'(SETUP_CYC - 1);
            ST_PULSE_LOW:  tmr_load_val = CNT_W'(LOW_CYC - 1);
            ST_PULSE_HIGH: tmr_load_val = CNT_W'(HIGH_CYC - 1);
            ST_TAIL:       tmr_load_val = CNT_W'(TAIL_CYC - 1);
            ST_DESELECT:   tmr_load_val = store_nx ? CNT_W'(STORE_CYC - 1) : CNT_W'(NOSTORE_CYC - 1);
            default:       tmr_load_val = '0;
        endcase
    end

    // State register and command context.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
            dir_q    <= 1'b1;
            store_q  <= 1'b0;
            arm_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            store_q <= store_nx;
            arm_q   <= arm_nx;
            if (accept) begin
                remain_q <= plan_count;
                dir_q    <= plan_up;
            end else if (step_en) begin
                remain_q <= remain_q - 1'b1;
            end
        end
    end

    assign dir_up = dir_q;

    // Registered line and status outputs, decoded from the next state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_n <= 1'b1;
            inc   <= 1'b1;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            busy <= (state_d != ST_IDLE);
            done <= (state_q == ST_RELEASE) && tmr_done;
            unique case (state_d)
                ST_IDLE:       begin sel_n <= 1'b1; inc <= 1'b1;     end
                ST_ARM_LOW:    begin sel_n <= 1'b1; inc <= 1'b0;     end
                ST_SETUP:      begin sel_n <= 1'b0; inc <= !arm_nx;  end
                ST_PULSE_LOW:  begin sel_n <= 1'b0; inc <= 1'b0;     end
                ST_PULSE_HIGH: begin sel_n <= 1'b0; inc <= 1'b1;     end
                ST_TAIL:       begin sel_n <= 1'b0; inc <= store_nx; end
                ST_DESELECT:   begin sel_n <= 1'b1; inc <= store_nx; end
                ST_RELEASE:    begin sel_n <= 1'b1; inc <= 1'b1;     end
                default:       begin sel_n <= 1'b1; inc <= 1'b1;     end
            endcase
        end
    end

endmodule

// File: rtl/wsm_checker.sv
module wsm_checker #(
    parameter int POS_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_n,
    input logic             inc,
    input logic             dir_up,
    input logic             busy,
    input logic             done,
    input logic [POS_W-1:0] cur_pos
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sel_n); // R10

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R11

    AST_DIR_HELD_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !sel_n && !$past(sel_n)) |-> $stable(dir_up)); // R6

    AST_POS_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (({1'b0, cur_pos} == {1'b0, $past(cur_pos)}) ||
                     ({1'b0, cur_pos} == {1'b0, $past(cur_pos)} + 1'b1) ||
                     ({1'b0, cur_pos} + 1'b1 == {1'b0, $past(cur_pos)}))); // R7

    AST_MOVE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && cur_pos != $past(cur_pos)) |-> !sel_n); // R7

    AST_STROBE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $fell(inc)) |-> busy); // R10

endmodule

bind wiper_step_master wsm_checker #(.POS_W(POS_W)) i_wsm_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_n   (sel_n),
    .inc     (inc),
    .dir_up  (dir_up),
    .busy    (busy),
    .done    (done),
    .cur_pos (cur_pos)
);

// File: tb/test_wiper_step_master.sv
module test_wiper_step_master;

    localparam int CK  = 5;
    localparam int POS_W = 5;
    localparam int STEP_W = 6;
    // Bench-side cycle counts, rounded up from the ns values passed below.
    localparam int B_SETUP   = (100 + CK - 1) / CK;             // 20
    localparam int B_LOW     = (150 + CK - 1) / CK;             // 30
    localparam int B_HIGH    = ((300 + CK - 1) / CK) - B_LOW;   // 30 (cycle bound wins over 20)
    localparam int B_HOLD    = (100 + CK - 1) / CK;             // 20
    localparam int B_TAIL    = (200 + CK - 1) / CK;             // 40
    localparam int B_STORE   = (2000 + CK - 1) / CK;            // 400
    localparam int B_NOSTORE = (250 + CK - 1) / CK;             // 50

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_abs = 1'b0;
    logic              cmd_up = 1'b0;
    logic              cmd_store = 1'b0;
    logic [STEP_W-1:0] cmd_steps = '0;
    logic [POS_W:0]    cmd_target = '0;
    logic              busy, done, sel_n, inc, dir_up;
    logic [POS_W-1:0]  cur_pos;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    wiper_step_master #(
        .CLK_NS(CK), .T_SEL_SETUP_NS(100), .T_DIR_SETUP_NS(60), .T_DIR_HOLD_NS(100),
        .T_INC_LOW_NS(150), .T_INC_HIGH_NS(100), .T_INC_CYCLE_NS(300), .T_TAIL_NS(200),
        .T_STORE_NS(2000), .T_NOSTORE_NS(250), .POS_W(POS_W), .STEP_W(STEP_W), .RESET_POS(0)
    ) i_wiper_step_master (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_abs(cmd_abs), .cmd_up(cmd_up),
        .cmd_store(cmd_store), .cmd_steps(cmd_steps), .cmd_target(cmd_target), .busy(busy),
        .done(done), .cur_pos(cur_pos), .sel_n(sel_n), .inc(inc), .dir_up(dir_up)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Behavioural slave and timing monitor, sampled at the falling clock edge.
    int cyc = 0;
    int slave_tap = 0;
    int slave_nv = 0;
    int pulse_cnt = 0;
    int sel_cnt = 0;
    int t_sel_fall = -100000, t_sel_rise = -100000, t_fall = -100000;
    int t_rise = -100000, t_edge = -100000, t_dir = -100000;
    bit last_store = 1'b1;
    logic p_sel = 1'b1, p_inc = 1'b1, p_dir = 1'b1;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (p_inc && !inc && !sel_n) begin
                check(cyc - t_sel_fall >= B_SETUP, "R2 select setup", cyc - t_sel_fall, B_SETUP);
                check(cyc - t_dir >= B_SETUP, "R2 direction setup", cyc - t_dir, B_SETUP);
                if (t_rise > t_sel_fall)
                    check(cyc - t_rise >= B_HIGH, "R3 high time", cyc - t_rise, B_HIGH);
                pulse_cnt++;
                if (dir_up && slave_tap < 31) slave_tap++;
                if (!dir_up && slave_tap > 0) slave_tap--;
                t_fall = cyc;
                t_edge = cyc;
            end
            if (!p_inc && inc) begin
                if (!sel_n) begin
                    check(cyc - t_fall >= B_LOW, "R3 low time", cyc - t_fall, B_LOW);
                    t_edge = cyc;
                end else if (!last_store) begin
                    check(cyc - t_sel_rise >= B_NOSTORE, "R5 no-store recovery",
                          cyc - t_sel_rise, B_NOSTORE);
                end
                t_rise = cyc;
            end
            if (!p_sel && sel_n) begin
                if (t_edge > t_sel_fall)
                    check(cyc - t_edge >= B_TAIL, "R4 tail", cyc - t_edge, B_TAIL);
                last_store = inc;
                if (inc) slave_nv = slave_tap;
                t_sel_rise = cyc;
            end
            if (p_sel && !sel_n) begin
                check(cyc - t_sel_rise >= (last_store ? B_STORE : B_NOSTORE), "R5 deselect time",
                      cyc - t_sel_rise, last_store ? B_STORE : B_NOSTORE);
                sel_cnt++;
                t_sel_fall = cyc;
            end
            if (p_dir != dir_up) begin
                check(p_sel == 1'b1, "R6 direction changed while selected", 0, 1);
                check(cyc - t_rise >= B_HOLD, "R6 direction hold", cyc - t_rise, B_HOLD);
                t_dir = cyc;
            end
        end
        p_sel = sel_n;
        p_inc = inc;
        p_dir = dir_up;
    end

    // Issue one command and check the whole transaction.
    task automatic run_cmd(input bit abs_m, input bit up, input int steps, input int target,
                           input bit store, input bit poke, input string req,
                           input int exp_pulses, input int exp_pos, input int exp_nv,
                           input int exp_busy);
        int p0, s0, bcnt;
        p0 = pulse_cnt;
        s0 = sel_cnt;
        bcnt = 0;
        @(negedge clk);
        cmd_abs = abs_m; cmd_up = up; cmd_steps = STEP_W'(steps);
        cmd_target = (POS_W+1)'(target); cmd_store = store; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) begin
            bcnt++;
            if (poke && bcnt == 50) begin
                cmd_abs = 1'b1; cmd_target = 7'd31; cmd_store = 1'b1; cmd_valid = 1'b1;
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        check(done == 1'b1, "R11 done at end", done, 1);
        check(bcnt == exp_busy, "R11 busy length", bcnt, exp_busy);
        check(pulse_cnt - p0 == exp_pulses, req, pulse_cnt - p0, exp_pulses);
        check(sel_cnt - s0 == 1, "R9 one select per command", sel_cnt - s0, 1);
        check(int'(cur_pos) == exp_pos, "R7 tracked position", cur_pos, exp_pos);
        check(slave_tap == exp_pos, "R7 slave tap", slave_tap, exp_pos);
        check(slave_nv == exp_nv, "R5 stored tap", slave_nv, exp_nv);
        @(negedge clk);
        check(done == 1'b0, "R11 done one cycle", done, 0);
        repeat (5) @(negedge clk);
        check(busy == 1'b0, "R10 stays idle", busy, 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(sel_n == 1'b1, "R1 sel_n", sel_n, 1);
        check(inc == 1'b1, "R1 inc", inc, 1);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(done == 1'b0, "R1 done", done, 0);
        check(cur_pos == '0, "R1 position", cur_pos, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_rel_up_store;
        run_cmd(0, 1, 5, 0, 1, 0, "R7 relative up pulses", 5, 5, 5,
                B_SETUP + 5*B_LOW + 5*B_HIGH + B_TAIL + B_STORE + B_HOLD);
    endtask

    task automatic t_rel_down_nostore;
        run_cmd(0, 0, 2, 0, 0, 0, "R7 relative down pulses", 2, 3, 5,
                B_SETUP + 2*B_LOW + B_HIGH + B_TAIL + B_NOSTORE + B_HOLD);
    endtask

    task automatic t_abs_up_store;
        run_cmd(1, 0, 0, 20, 1, 0, "R8 absolute up pulses", 17, 20, 20,
                B_SETUP + 17*(B_LOW + B_HIGH) + B_TAIL + B_STORE + B_HOLD);
    endtask

    task automatic t_abs_clamp;
        run_cmd(1, 0, 0, 40, 0, 0, "R8 clamped target pulses", 11, 31, 20,
                B_SETUP + 11*B_LOW + 10*B_HIGH + B_TAIL + B_NOSTORE + B_HOLD);
    endtask

    task automatic t_rel_saturated_store;
        run_cmd(0, 1, 10, 0, 1, 0, "R9 zero-step store pulses", 0, 31, 31,
                B_SETUP + B_TAIL + B_STORE + B_HOLD);
    endtask

    task automatic t_busy_ignored;
        run_cmd(0, 0, 63, 0, 0, 1, "R10 command during busy ignored", 31, 0, 31,
                B_SETUP + 31*B_LOW + 30*B_HIGH + B_TAIL + B_NOSTORE + B_HOLD);
    endtask

    task automatic t_zero_nostore;
        run_cmd(1, 1, 0, 0, 0, 0, "R9 zero-step no-store pulses", 0, 0, 31,
                B_HOLD + B_SETUP + B_TAIL + B_NOSTORE + B_HOLD);
    endtask

    task automatic t_abs_down_store;
        run_cmd(0, 1, 3, 0, 0, 0, "R7 relative up pulses", 3, 3, 31,
                B_SETUP + 3*B_LOW + 2*B_HIGH + B_TAIL + B_NOSTORE + B_HOLD);
        check(dir_up == 1'b1, "R8 direction up", dir_up, 1);
        run_cmd(1, 1, 0, 1, 1, 0, "R8 absolute down pulses", 2, 1, 1,
                B_SETUP + 2*(B_LOW + B_HIGH) + B_TAIL + B_STORE + B_HOLD);
        check(dir_up == 1'b0, "R8 direction down", dir_up, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_rel_up_store();
        t_rel_down_nostore();
        t_abs_up_store();
        t_abs_clamp();
        t_rel_saturated_store();
        t_busy_ignored();
        t_zero_nostore();
        t_abs_down_store();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule